// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counter behind four memory-mapped word registers. The registers hold a reload value, the live count, a control word and a sticky expiry flag. An 8-bit prescaler stretches every count step to P+1 clock cycles. When the count runs out, the expiry flag is set. The timer then either stops at zero or refills itself from the reload register and keeps going. A level interrupt shows the flag whenever the interrupt enable is on.

Software drives the block through a simple synchronous register port. Accesses are whole 32-bit words only. A read returns its data one cycle after it is issued. Typical use is to program the reload value and the control word, then wait for the interrupt and clear the flag by writing a one to it. A count written while the timer runs takes effect at once and restarts the prescaler.

Top module: `tick_countdown_timer`

## Requirements
- R1: After reset the reload, count, control and flag registers are zero, `irq` is 0 and `bus_rdata` is 0.
- R2: Word offsets: 0x0 reload, 0x4 count, 0x8 control, 0xC flag (bit 0). A read issued in one cycle appears on `bus_rdata` after the next clock edge. `bus_rdata` is zero in any cycle after which no read was issued. Other offsets read as zero and ignore writes. Control reads back as enable at bit 0, auto-reload at bit 1, interrupt enable at bit 2 and prescaler P at bits 15:8, with zeros elsewhere.
- R3: When the timer is enabled with count N and prescaler P, the count steps down once every P+1 cycles. The flag is set N*(P+1) edges after the loading or enabling write.
- R4: On expiry the flag is set. With auto-reload off, the count then stays at zero.
- R5: On expiry with auto-reload on, the count is refilled from the reload register and counting goes on.
- R6: `irq` equals the flag ANDed with control bit 2. It follows a change of either in the same cycle the register changes.
- R7: Writing the flag register clears the flag only when data bit 0 is 1. An expiry in the same cycle as the clear leaves the flag set.
- R8: A write to 0x0 sets both the reload value and the count. A write to 0x4 sets only the count. Either write clears the prescaler, so an enabled timer restarts from the new value. A count write in the same cycle as an expiry takes precedence over the refill.
- R9: Writing enable=1 while the timer is enabled with a nonzero count leaves the count running. Otherwise such a write clears the prescaler. If auto-reload is also written as 1, the write also copies the reload value into the count; if not, the count is kept.
- R10: An enabled timer whose count is zero never sets the flag.
- R11: The count register reads zero while the timer is disabled or its count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of functions can land on the same edge. In the first, a count expiry coincides with a software clear of the flag. In the second, a count expiry coincides with a software write of a new count. The bench provokes both by counting edges from a known load so that the write lands exactly on the expiry edge. It then judges the result by `irq` staying high and by the next count read showing the written value, not the refill. A behavioural model compares `irq` and `bus_rdata` on every cycle as well.

// File: rtl/tick_countdown_timer.sv
module tick_countdown_timer #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_RELOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_COUNT  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_FLAG   = ADDR_W'(12);
  localparam int               PRE_LSB    = 8;

  logic [CNT_W-1:0] reload_q, count_q, count_nx;
  logic [PRE_W-1:0] presc_q, pre_q, pre_nx;
  logic             en_q, auto_q, ie_q, status_q;

  wire wr_en   = bus_sel & bus_wr;
  wire rd_en   = bus_sel & ~bus_wr;
  wire w_load  = wr_en && bus_addr == OFS_RELOAD;
  wire w_count = wr_en && bus_addr == OFS_COUNT;
  wire w_ctrl  = wr_en && bus_addr == OFS_CTRL;
  wire w_flag  = wr_en && bus_addr == OFS_FLAG;

  wire running = en_q && count_q != '0;
  wire step    = running && pre_q >= presc_q;
  wire expire  = step && count_q == CNT_W'(1);
  wire unused_wdata = ^bus_wdata;

  assign irq = status_q & ie_q;

  always_comb begin
    count_nx = count_q;
    pre_nx   = pre_q;
    if (running) begin
      if (step) begin
        pre_nx   = '0;
        count_nx = expire ? (auto_q ? reload_q : '0) : count_q - CNT_W'(1);
      end else begin
        pre_nx = pre_q + PRE_W'(1);
      end
    end
    if (w_load || w_count) begin
      count_nx = bus_wdata[CNT_W-1:0];
      pre_nx   = '0;
    end
    if (w_ctrl && bus_wdata[0] && !running) begin
      pre_nx = '0;
      if (bus_wdata[1]) count_nx = reload_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q  <= '0;
      count_q   <= '0;
      pre_q     <= '0;
      presc_q   <= '0;
      en_q      <= 1'b0;
      auto_q    <= 1'b0;
      ie_q      <= 1'b0;
      status_q  <= 1'b0;
      bus_rdata <= '0;
    end else begin
      count_q  <= count_nx;
      pre_q    <= pre_nx;
      status_q <= expire | (status_q & ~(w_flag & bus_wdata[0]));
      if (w_load) reload_q <= bus_wdata[CNT_W-1:0];
      if (w_ctrl) begin
        en_q    <= bus_wdata[0];
        auto_q  <= bus_wdata[1];
        ie_q    <= bus_wdata[2];
        presc_q <= bus_wdata[PRE_LSB +: PRE_W];
      end
      bus_rdata <= '0;
      if (rd_en) begin
        case (bus_addr)
          OFS_RELOAD: bus_rdata <= 32'(reload_q);
          OFS_COUNT:  bus_rdata <= running ? 32'(count_q) : '0;
          OFS_CTRL:   bus_rdata <= (32'(presc_q) << PRE_LSB) | {29'd0, ie_q, auto_q, en_q};
          OFS_FLAG:   bus_rdata <= {31'd0, status_q};
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

module tick_countdown_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [CNT_W-1:0]  count_q,
  input logic              en_q,
  input logic              status_q
);
  wire any_wr   = bus_sel && bus_wr;
  wire flag_clr = any_wr && bus_addr == ADDR_W'(12) && bus_wdata[0];

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> bus_rdata == 32'd0);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !flag_clr) |=> status_q);

  assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q) |-> $past(en_q && count_q == CNT_W'(1)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !any_wr) |=> $stable(count_q));

  assert_zero_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count_q == '0 && !any_wr) |=> ($stable(status_q) && count_q == '0));

  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && count_q > CNT_W'(1) && !any_wr) |=>
      (count_q == $past(count_q) || count_q == $past(count_q) - CNT_W'(1)));
endmodule

bind tick_countdown_timer tick_countdown_timer_chk #(
  .CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .count_q(count_q), .en_q(en_q), .status_q(status_q)
);

// File: tb/test_tick_countdown_timer.sv
module test_tick_countdown_timer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, sel = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  tick_countdown_timer i_tick_countdown_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int unsigned m_reload, m_count, m_rdata;
  int          m_presc, m_pre;
  bit          m_en, m_auto, m_ie, m_status;
  always @(posedge clk) begin
    bit run, fire;
    int unsigned rd;
    if (!rst_n) begin
      m_reload = 0; m_count = 0; m_rdata = 0; m_presc = 0; m_pre = 0;
      m_en = 0; m_auto = 0; m_ie = 0; m_status = 0;
    end else begin
      rd = 0;
      if (sel && !wr) begin
        if (addr == 0) rd = m_reload;
        else if (addr == 4) rd = (m_en && m_count != 0) ? m_count : 0;
        else if (addr == 8) rd = (m_presc << 8) | (int'(m_ie) << 2) | (int'(m_auto) << 1) | int'(m_en);
        else if (addr == 12) rd = int'(m_status);
      end
      m_rdata = rd;
      run = m_en && m_count != 0;
      fire = 0;
      if (run) begin
        if (m_pre >= m_presc) begin
          m_pre = 0;
          if (m_count == 1) begin fire = 1; m_count = m_auto ? m_reload : 0; end
          else m_count = m_count - 1;
        end else m_pre = m_pre + 1;
      end
      if (sel && wr) begin
        if (addr == 0) begin m_reload = wdata; m_count = wdata; m_pre = 0; end
        else if (addr == 4) begin m_count = wdata; m_pre = 0; end
        else if (addr == 8) begin
          if (wdata[0] && !run) begin m_pre = 0; if (wdata[1]) m_count = m_reload; end
          m_en = wdata[0]; m_auto = wdata[1]; m_ie = wdata[2]; m_presc = int'(wdata[15:8]);
        end else if (addr == 12 && wdata[0]) m_status = 0;
      end
      if (fire) m_status = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model rdata", rdata, m_rdata);
      check("R6 model irq", {31'd0, irq}, {31'd0, m_status && m_ie});
    end
  end

  task automatic bwr(logic [4:0] a, logic [31:0] d);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic brd(logic [4:0] a, output logic [31:0] v);
    sel = 1; wr = 0; addr = a;
    @(negedge clk);
    sel = 0;
    v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rdata", rdata, 32'd0);
    for (int i = 0; i < 4; i++) begin
      brd(5'(i * 4), v);
      check("R1 reg", v, 32'd0);
    end
    // one-shot with P=2
    bwr(5'h0, 32'd5);
    brd(5'h4, v); check("R11 disabled count", v, 32'd0);
    brd(5'h0, v); check("R8 reload", v, 32'd5);
    bwr(5'h8, 32'h0000_0205);
    idle(14); check("R3 before expiry", {31'd0, irq}, 32'd0);
    idle(1);  check("R3 at expiry", {31'd0, irq}, 32'd1);
    brd(5'h4, v); check("R4 stays zero", v, 32'd0);
    idle(20);
    brd(5'hC, v); check("R4 flag set", v, 32'd1);
    // irq gating, clear rules, zero count
    bwr(5'h8, 32'h0000_0201); check("R6 gated off", {31'd0, irq}, 32'd0);
    bwr(5'hC, 32'd0);
    brd(5'hC, v); check("R7 zero write", v, 32'd1);
    bwr(5'h8, 32'h0000_0205); check("R6 gated on", {31'd0, irq}, 32'd1);
    bwr(5'hC, 32'd1); check("R7 cleared", {31'd0, irq}, 32'd0);
    idle(40);
    brd(5'hC, v); check("R10 zero count quiet", v, 32'd0);
    // count-only write and restart by reload write
    bwr(5'h4, 32'h20);
    brd(5'h0, v); check("R8 count write keeps reload", v, 32'd5);
    bwr(5'h0, 32'd3);
    idle(8); check("R8 restart before", {31'd0, irq}, 32'd0);
    idle(1); check("R8 restart expiry", {31'd0, irq}, 32'd1);
    // auto-reload, P=0
    bwr(5'hC, 32'd1);
    bwr(5'h8, 32'h0000_0007);
    brd(5'h4, v); check("R9 enable copies reload", v, 32'd3);
    idle(2); check("R5 expiry", {31'd0, irq}, 32'd1);
    brd(5'h4, v); check("R5 refilled", v, 32'd3);
    // re-enable while running
    bwr(5'h4, 32'd100);
    bwr(5'h8, 32'h0000_0007);
    brd(5'h4, v); check("R9 running untouched", v, 32'd99);
    // enable without auto keeps count
    bwr(5'h8, 32'd0);
    bwr(5'hC, 32'd1);
    bwr(5'h4, 32'd2);
    brd(5'h4, v); check("R11 stopped reads zero", v, 32'd0);
    bwr(5'h8, 32'h0000_0005);
    brd(5'h4, v); check("R9 keeps count", v, 32'd2);
    // clear on the expiry edge
    bwr(5'hC, 32'd1); check("R7 expiry beats clear", {31'd0, irq}, 32'd1);
    // count write on the expiry edge
    bwr(5'h4, 32'd3);
    bwr(5'hC, 32'd1);
    idle(1);
    bwr(5'h4, 32'd7); check("R8 flag on collision", {31'd0, irq}, 32'd1);
    brd(5'h4, v); check("R8 write beats refill", v, 32'd7);
    // unmapped offsets and control layout
    bwr(5'h8, 32'd0);
    bwr(5'h10, 32'hFFFF_FFFF);
    brd(5'h10, v); check("R2 unmapped read", v, 32'd0);
    brd(5'h8, v); check("R2 unmapped write ignored", v, 32'd0);
    brd(5'h0, v); check("R2 reload intact", v, 32'd3);
    bwr(5'h8, 32'hFFFF_AB06);
    brd(5'h8, v); check("R2 control layout", v, 32'h0000_AB06);
    done = 1;
    summary();
    $finish;
  end
endmodule